// File: doc/BRIEF.md
# I2C Slave Address Match Flags

This block decides whether the first byte seen after a bus start condition is meant for this device, and it holds two sticky status flags. The address flag records that the first frame carried the device's own 7-bit address, or a general call where the format settings allow one. The general-call flag records that the first frame was the all-zero general-call byte. The bit-level serial engine upstream supplies a start pulse and a strobe for each received byte. The block compares only the first byte after each start. Later bytes are ignored until the next start arrives, and that includes a repeated start.

Software clears the flags in three ways. It can touch the data register in the direction the transfer is running. It can write 0 to a flag that it has already read as 1. Or the interface can switch into master mode. If a set and a clear land in the same cycle, the set wins. Both flags are registered, so they change on the clock edge after the strobe that causes the change.

Top module: `i2c_addr_flags`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `addr_hit_flag` and `gcall_flag` read 0. The same reset also clears the read-as-one memory of both flags.
- R2: Only the first `frame_valid` strobe after a `start_det` pulse is examined. Later frames change nothing until another `start_det` arrives, and any start (including a repeated start) re-arms the examination.
- R3: The address match compares `frame_data[7:1]` with `own_addr[6:0]`. `frame_data[0]`, the read/write bit, plays no part in the compare.
- R4: A general call is a frame equal to 0x00 in all eight bits. The frame 0x01 is not a general call.
- R5: `addr_hit_flag` sets when the examined frame matches the own address or is a general call, `slave_rx` is 1, and `fmt_fs` is 0.
- R6: `gcall_flag` sets when the examined frame is a general call, `slave_rx` is 1, and `fmt_fs` or `fmt_fsx` is 0. With `fmt_fs`=1 and `fmt_fsx`=0, a general call sets `gcall_flag` only. With both bits at 1, neither flag sets.
- R7: Both flags clear on `dr_wr` while `xmit_dir`=1, and on `dr_rd` while `xmit_dir`=0. `dr_wr` with `xmit_dir`=0 and `dr_rd` with `xmit_dir`=1 have no effect.
- R8: On `cpu_wr`, bit 1 of `cpu_wdata` applies to `addr_hit_flag` and bit 0 applies to `gcall_flag`. Writing 0 clears a flag only if an earlier `cpu_rd` saw that flag at 1 and the flag has not cleared since. Writing 1 has no effect, and neither does writing 0 without that earlier read.
- R9: A rising edge on `master_mode` clears both flags.
- R10: A set condition in the same cycle as any clear condition leaves the flag at 1.
- R11: A flag changes on the clock edge that samples its cause, so it is visible in the following cycle. With `slave_rx`=0, no frame sets either flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_det | input | 1 | One-cycle pulse when a start or repeated start is detected |
| frame_valid | input | 1 | One-cycle strobe when a received byte is complete |
| frame_data | input | 8 | Received byte; bit 0 is the read/write bit |
| own_addr | input | 7 | Device's own 7-bit slave address |
| slave_rx | input | 1 | Interface is in slave-receive mode |
| master_mode | input | 1 | Interface is in master mode |
| fmt_fs | input | 1 | Format select; 1 suppresses address recognition |
| fmt_fsx | input | 1 | Extended format select |
| xmit_dir | input | 1 | 1 while transmitting, 0 while receiving |
| dr_wr | input | 1 | Software write strobe to the data register |
| dr_rd | input | 1 | Software read strobe from the data register |
| cpu_rd | input | 1 | Software read of the flag register |
| cpu_wr | input | 1 | Software write of the flag register |
| cpu_wdata | input | 2 | Write data: bit 1 address flag, bit 0 general-call flag |
| addr_hit_flag | output | 1 | Own address or general call recognised |
| gcall_flag | output | 1 | General call seen |

## Verification
The hardest state to reach from the ports is a flag that sits at 1 with its read-as-one memory armed and then collides with another event. Two collisions matter. In one, the flag is cleared by another path and later set again, and the software write of 0 that follows must be ignored. In the other, a data-register clear lands in the same cycle as a new first frame. The stimulus builds both by hand. It reads the flag, clears it through the data register, replays a start and a matching frame, and only then writes 0. A separate step raises the frame strobe in the same cycle as a receive-side data read. A behavioural model in the bench tracks the arm bits, so every cycle of these sequences is compared.

// File: rtl/adet_pkg.sv
package adet_pkg;
  localparam int ADDR_W_DEF  = 7;
  localparam int NUM_FLAGS   = 2;
  localparam int IDX_GCALL   = 0;
  localparam int IDX_ADDR    = 1;
endpackage

// File: rtl/adet_frame_gate.sv
module adet_frame_gate #(
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic               valid_i,
  input  logic [FRAME_W-1:0] data_i,
  output logic               eval_o,
  output logic [FRAME_W-1:0] frame_o
);
  logic pending_q;

  always_ff @(posedge clk) begin
    if (rst)          pending_q <= 1'b0;
    else if (start_i) pending_q <= 1'b1;
    else if (valid_i) pending_q <= 1'b0;
  end

  assign eval_o  = valid_i & pending_q;
  assign frame_o = data_i;
endmodule

// File: rtl/adet_decode.sv
module adet_decode #(
  parameter int ADDR_W    = 7,
  parameter int NUM_FLAGS = 2,
  parameter int IDX_ADDR  = 1,
  parameter int IDX_GCALL = 0
) (
  input  logic                 eval_i,
  input  logic [ADDR_W:0]      frame_i,
  input  logic [ADDR_W-1:0]    own_addr_i,
  input  logic                 slave_rx_i,
  input  logic                 fs_i,
  input  logic                 fsx_i,
  output logic [NUM_FLAGS-1:0] set_o
);
  localparam int FRAME_W = ADDR_W + 1;
  localparam logic [FRAME_W-1:0] GCALL_CODE = '0;

  logic addr_eq, is_gcall, qualified;

  always_comb begin
    addr_eq   = (frame_i[FRAME_W-1:1] == own_addr_i);
    is_gcall  = (frame_i == GCALL_CODE);
    qualified = eval_i & slave_rx_i;
    set_o            = '0;
    set_o[IDX_ADDR]  = qualified & ~fs_i & (addr_eq | is_gcall);
    set_o[IDX_GCALL] = qualified & is_gcall & (~fs_i | ~fsx_i);
  end
endmodule

// File: rtl/adet_clear_ctl.sv
module adet_clear_ctl (
  input  logic clk,
  input  logic master_i,
  input  logic xmit_i,
  input  logic dr_wr_i,
  input  logic dr_rd_i,
  output logic clr_o
);
  logic master_q;

  always_ff @(posedge clk) master_q <= master_i;

  assign clr_o = (dr_wr_i & xmit_i) | (dr_rd_i & ~xmit_i) | (master_i & ~master_q);
endmodule

// File: rtl/adet_flag_bit.sv
module adet_flag_bit (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o
);
  logic flag_q, arm_q, wclr, clr_any, drop;

  always_comb begin
    wclr    = wr_i & ~wbit_i & arm_q;
    clr_any = clr_i | wclr;
    drop    = clr_any & ~set_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (set_i)     flag_q <= 1'b1;
      else if (drop) flag_q <= 1'b0;
      if (drop)                arm_q <= 1'b0;
      else if (rd_i & flag_q)  arm_q <= 1'b1;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/i2c_addr_flags.sv
module i2c_addr_flags #(
  parameter int ADDR_W = adet_pkg::ADDR_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_det,
  input  logic              frame_valid,
  input  logic [ADDR_W:0]   frame_data,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              slave_rx,
  input  logic              master_mode,
  input  logic              fmt_fs,
  input  logic              fmt_fsx,
  input  logic              xmit_dir,
  input  logic              dr_wr,
  input  logic              dr_rd,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [1:0]        cpu_wdata,
  output logic              addr_hit_flag,
  output logic              gcall_flag
);
  import adet_pkg::*;
  localparam int FRAME_W = ADDR_W + 1;

  logic               eval;
  logic [FRAME_W-1:0] frame;
  logic [NUM_FLAGS-1:0] set_vec, flag_vec;
  logic               clr_common;

  adet_frame_gate #(.FRAME_W(FRAME_W)) u_gate (
    .clk(clk), .rst(rst), .start_i(start_det), .valid_i(frame_valid),
    .data_i(frame_data), .eval_o(eval), .frame_o(frame)
  );

  adet_decode #(
    .ADDR_W(ADDR_W), .NUM_FLAGS(NUM_FLAGS), .IDX_ADDR(IDX_ADDR), .IDX_GCALL(IDX_GCALL)
  ) u_dec (
    .eval_i(eval), .frame_i(frame), .own_addr_i(own_addr), .slave_rx_i(slave_rx),
    .fs_i(fmt_fs), .fsx_i(fmt_fsx), .set_o(set_vec)
  );

  adet_clear_ctl u_clr (
    .clk(clk), .master_i(master_mode), .xmit_i(xmit_dir),
    .dr_wr_i(dr_wr), .dr_rd_i(dr_rd), .clr_o(clr_common)
  );

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    adet_flag_bit u_bit (
      .clk(clk), .rst(rst), .set_i(set_vec[i]), .clr_i(clr_common),
      .rd_i(cpu_rd), .wr_i(cpu_wr), .wbit_i(cpu_wdata[i]), .flag_o(flag_vec[i])
    );
  end

  assign addr_hit_flag = flag_vec[IDX_ADDR];
  assign gcall_flag    = flag_vec[IDX_GCALL];
endmodule

// File: rtl/i2c_addr_flags_chk.sv
module i2c_addr_flags_chk #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              frame_valid,
  input logic [ADDR_W:0]   frame_data,
  input logic [ADDR_W-1:0] own_addr,
  input logic              slave_rx,
  input logic              master_mode,
  input logic              fmt_fs,
  input logic              fmt_fsx,
  input logic              xmit_dir,
  input logic              dr_wr,
  input logic              dr_rd,
  input logic              cpu_wr,
  input logic [1:0]        cpu_wdata,
  input logic              addr_hit_flag,
  input logic              gcall_flag
);
  // R11: any rise needs a frame strobe on the edge before
  a_r11_rise_needs_frame: assert property (@(posedge clk) disable iff (rst)
    ($rose(addr_hit_flag) || $rose(gcall_flag)) |-> $past(frame_valid) && $past(slave_rx));

  // R3 / R5: address flag rises only on a matching or general-call frame with FS at 0
  a_r5_addr_source: assert property (@(posedge clk) disable iff (rst)
    $rose(addr_hit_flag) |-> !$past(fmt_fs) &&
      (($past(frame_data[ADDR_W:1]) == $past(own_addr)) || ($past(frame_data) == '0)));

  // R6: general-call flag rises only on an all-zero frame with a permitting format
  a_r6_gcall_source: assert property (@(posedge clk) disable iff (rst)
    $rose(gcall_flag) |-> ($past(frame_data) == '0) && (!$past(fmt_fs) || !$past(fmt_fsx)));

  // R7: receive-side data read clears both flags
  a_r7_dr_read_clear: assert property (@(posedge clk) disable iff (rst)
    (dr_rd && !xmit_dir && !frame_valid) |=> !addr_hit_flag && !gcall_flag);

  // R7: transmit-side data write clears both flags
  a_r7_dr_write_clear: assert property (@(posedge clk) disable iff (rst)
    (dr_wr && xmit_dir && !frame_valid) |=> !addr_hit_flag && !gcall_flag);

  // R9: entering master mode clears both flags
  a_r9_master_clear: assert property (@(posedge clk) disable iff (rst)
    ($rose(master_mode) && !frame_valid) |=> !addr_hit_flag && !gcall_flag);

  // R8: writing 1 leaves a set address flag in place
  a_r8_write_one_keeps: assert property (@(posedge clk) disable iff (rst)
    (addr_hit_flag && cpu_wr && cpu_wdata[1] && !dr_rd && !dr_wr && !$rose(master_mode))
      |=> addr_hit_flag);
endmodule

bind i2c_addr_flags i2c_addr_flags_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .frame_valid(frame_valid), .frame_data(frame_data),
  .own_addr(own_addr), .slave_rx(slave_rx), .master_mode(master_mode),
  .fmt_fs(fmt_fs), .fmt_fsx(fmt_fsx), .xmit_dir(xmit_dir), .dr_wr(dr_wr),
  .dr_rd(dr_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
  .addr_hit_flag(addr_hit_flag), .gcall_flag(gcall_flag)
);

// File: tb/tb_i2c_addr_flags.sv
module tb_i2c_addr_flags;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_det = 0, frame_valid = 0, slave_rx = 0, master_mode = 0;
  logic fmt_fs = 0, fmt_fsx = 0, xmit_dir = 0, dr_wr = 0, dr_rd = 0;
  logic cpu_rd = 0, cpu_wr = 0;
  logic [1:0] cpu_wdata = 2'b00;
  logic [7:0] frame_data = 8'h00;
  logic [6:0] own_addr = 7'h5A;
  logic addr_hit_flag, gcall_flag;

  int checks = 0, failures = 0;
  string phase = "R1";
  bit finished = 0;

  // reference model state
  bit m_addr = 0, m_gc = 0, m_arm_a = 0, m_arm_g = 0, m_pend = 0, m_mprev = 0;

  always #10 clk = ~clk;

  i2c_addr_flags dut (
    .clk(clk), .rst(rst), .start_det(start_det), .frame_valid(frame_valid),
    .frame_data(frame_data), .own_addr(own_addr), .slave_rx(slave_rx),
    .master_mode(master_mode), .fmt_fs(fmt_fs), .fmt_fsx(fmt_fsx),
    .xmit_dir(xmit_dir), .dr_wr(dr_wr), .dr_rd(dr_rd), .cpu_rd(cpu_rd),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .addr_hit_flag(addr_hit_flag),
    .gcall_flag(gcall_flag)
  );

  // behavioural model, evaluated at each rising edge
  always @(posedge clk) begin
    bit first, gc, hit, s_a, s_g, common, c_a, c_g;
    bit n_addr, n_gc;
    if (rst) begin
      m_addr = 0; m_gc = 0; m_arm_a = 0; m_arm_g = 0; m_pend = 0;
    end else begin
      first  = frame_valid && m_pend;
      gc     = (frame_data == 8'h00);
      hit    = (frame_data[7:1] == own_addr);
      s_a    = first && slave_rx && !fmt_fs && (hit || gc);
      s_g    = first && slave_rx && gc && (!fmt_fs || !fmt_fsx);
      common = (dr_wr && xmit_dir) || (dr_rd && !xmit_dir) || (master_mode && !m_mprev);
      c_a    = common || (cpu_wr && !cpu_wdata[1] && m_arm_a);
      c_g    = common || (cpu_wr && !cpu_wdata[0] && m_arm_g);
      n_addr = s_a ? 1'b1 : (c_a ? 1'b0 : m_addr);
      n_gc   = s_g ? 1'b1 : (c_g ? 1'b0 : m_gc);
      if (c_a && !s_a) m_arm_a = 0; else if (cpu_rd && m_addr) m_arm_a = 1;
      if (c_g && !s_g) m_arm_g = 0; else if (cpu_rd && m_gc)   m_arm_g = 1;
      m_addr = n_addr; m_gc = n_gc;
      if (start_det) m_pend = 1; else if (frame_valid) m_pend = 0;
    end
    m_mprev = master_mode;
  end

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      checks++;
      if (addr_hit_flag !== m_addr || gcall_flag !== m_gc) begin
        failures++;
        $display("FAIL %s model compare: actual addr=%b gc=%b expected addr=%b gc=%b",
                 phase, addr_hit_flag, gcall_flag, m_addr, m_gc);
      end
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic expect_flags(bit ea, bit eg, string req);
    checks++;
    if (addr_hit_flag !== ea || gcall_flag !== eg) begin
      failures++;
      $display("FAIL %s: actual addr=%b gc=%b expected addr=%b gc=%b",
               req, addr_hit_flag, gcall_flag, ea, eg);
    end
  endtask

  task automatic do_start(); start_det = 1; tick(); start_det = 0; endtask
  task automatic do_frame(logic [7:0] b);
    frame_valid = 1; frame_data = b; tick(); frame_valid = 0;
  endtask
  task automatic do_dr_rd(); dr_rd = 1; tick(); dr_rd = 0; endtask
  task automatic do_dr_wr(); dr_wr = 1; tick(); dr_wr = 0; endtask
  task automatic do_cpu_rd(); cpu_rd = 1; tick(); cpu_rd = 0; endtask
  task automatic do_cpu_wr(logic [1:0] v);
    cpu_wr = 1; cpu_wdata = v; tick(); cpu_wr = 0; cpu_wdata = 2'b00;
  endtask
  task automatic clear_all(); xmit_dir = 0; do_dr_rd(); endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    phase = "R1"; expect_flags(0, 0, "R1 in reset");
    rst = 0; tick();
    expect_flags(0, 0, "R1 after reset");

    slave_rx = 1;
    // R3/R5: own address with read bit set
    phase = "R3"; do_start(); do_frame({7'h5A, 1'b1});
    expect_flags(1, 0, "R3 own address, rw=1");
    phase = "R7"; xmit_dir = 0; do_dr_rd();
    expect_flags(0, 0, "R7 receive read clears");

    // R4/R5/R6: general call with FS=0
    phase = "R6"; do_start(); do_frame(8'h00);
    expect_flags(1, 1, "R6 general call FS=0 FSX=0");
    phase = "R7"; xmit_dir = 0; do_dr_wr();
    expect_flags(1, 1, "R7 write while receiving ignored");
    xmit_dir = 1; do_dr_rd();
    expect_flags(1, 1, "R7 read while transmitting ignored");
    do_dr_wr();
    expect_flags(0, 0, "R7 transmit write clears");
    xmit_dir = 0;

    // R4: 0x01 is not a general call
    phase = "R4"; do_start(); do_frame(8'h01);
    expect_flags(0, 0, "R4 frame 0x01 not general call");

    // R2: only the first frame after a start counts
    phase = "R2"; do_start(); do_frame(8'h33); do_frame({7'h5A, 1'b0});
    expect_flags(0, 0, "R2 later frame ignored");
    do_frame(8'h00);
    expect_flags(0, 0, "R2 later general call ignored");
    do_start(); do_frame({7'h5A, 1'b0});
    expect_flags(1, 0, "R2 repeated start re-arms");
    clear_all();

    // R8: software write of 0
    phase = "R8"; do_start(); do_frame(8'h00);
    do_cpu_wr(2'b00);
    expect_flags(1, 1, "R8 write 0 without read ignored");
    do_cpu_rd(); do_cpu_wr(2'b11);
    expect_flags(1, 1, "R8 write 1 ignored");
    do_cpu_wr(2'b10);
    expect_flags(1, 0, "R8 bit0 clears general-call flag");
    do_cpu_wr(2'b01);
    expect_flags(0, 0, "R8 bit1 clears address flag");
    // arm lost when flag clears another way
    do_start(); do_frame({7'h5A, 1'b0}); do_cpu_rd(); do_dr_rd();
    do_start(); do_frame({7'h5A, 1'b0}); do_cpu_wr(2'b00);
    expect_flags(1, 0, "R8 arm dropped by earlier clear");
    clear_all();

    // R6: format-select combinations
    phase = "R6"; fmt_fs = 1; fmt_fsx = 0; do_start(); do_frame(8'h00);
    expect_flags(0, 1, "R6 FS=1 FSX=0 general call only");
    clear_all();
    fmt_fsx = 1; do_start(); do_frame(8'h00);
    expect_flags(0, 0, "R6 FS=1 FSX=1 nothing");
    phase = "R5"; do_start(); do_frame({7'h5A, 1'b0});
    expect_flags(0, 0, "R5 FS=1 blocks address match");
    fmt_fs = 0; do_start(); do_frame(8'h00);
    expect_flags(1, 1, "R6 FS=0 FSX=1 both");
    fmt_fsx = 0;

    // R9: entering master mode
    phase = "R9"; slave_rx = 0; master_mode = 1; tick();
    expect_flags(0, 0, "R9 master entry clears");
    do_start(); do_frame(8'h00);
    expect_flags(0, 0, "R11 no set outside slave receive");
    master_mode = 0; slave_rx = 1; tick();

    // R10: set beats clear in the same cycle
    phase = "R10"; do_start();
    frame_valid = 1; frame_data = {7'h5A, 1'b1}; dr_rd = 1; xmit_dir = 0;
    tick(); frame_valid = 0; dr_rd = 0;
    expect_flags(1, 0, "R10 set wins over data read");
    clear_all();

    // R11: flag visible one cycle after strobe, not before
    phase = "R11"; do_start(); frame_valid = 1; frame_data = 8'h00;
    #5; expect_flags(0, 0, "R11 not yet set before edge");
    tick(); frame_valid = 0;
    expect_flags(1, 1, "R11 set after edge");

    // R1: reset mid-run clears flags and arm bits
    phase = "R1"; do_cpu_rd(); rst = 1; tick(); rst = 0; tick();
    expect_flags(0, 0, "R1 reset clears flags");
    do_start(); do_frame(8'h00); do_cpu_wr(2'b00);
    expect_flags(1, 1, "R1 reset cleared arm bits");

    tick();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule